// File: doc/BRIEF.md
# Grouped Interrupt Expander

This block lets a processor with a small number of interrupt inputs serve many peripheral sources. It gathers 96 source lines into 12 groups of 8 and drives one request line per group. Each group keeps a pending-flag register and an enable register. Each group also has one bit in a shared acknowledge register. A group raises its line once. It then stays silent until software re-arms it through the acknowledge register.

When the processor accepts a group's request, it presents the group index on the accept port. In the same cycle the block returns a vector number. The vector names the highest-priority source that is flagged and enabled in that group. At the next clock edge the block clears that source's flag and sets the group's acknowledge bit. Software reaches every register through a simple single-cycle register bus. A global enable bit gates all requests and all vector returns.

Top module: `irqx_top`

## Requirements
- R1: After reset, every flag, enable and acknowledge bit is 0, the control register reads 0, and no request line is high.
- R2: Group g (index 0..11) has its flag register at address 0x10+g and its enable register at address 0x20+g. Only bits 7:0 hold state. Bits 15:8 read as 0, and writes to them are ignored.
- R3: A high level on a source input sets that source's flag at the next edge. A bus write stores the written value into the flags, ORed with any arrivals in the same cycle, so writing 1 forces a source pending.
- R4: cpu_req[g] is high exactly when the global enable is 1, acknowledge bit g is 0, and group g has at least one source that is both flagged and enabled.
- R5: While cpu_ack_valid is high and cpu_ack_grp names a group whose request is high, vec_valid is high in the same cycle. vec_num is then g*8 + b, where b is the lowest flagged-and-enabled bit of that group.
- R6: A vector fetch clears the chosen flag bit at the next edge, leaves the other flags unchanged, and sets acknowledge bit g, which drops cpu_req[g].
- R7: The acknowledge register is at address 0x01, with bit g belonging to group g. Writing 1 to a bit clears it, and writing 0 has no effect. While the bit is set the group stays silent. If a fetch and a clearing write reach the same group in the same cycle, the bit ends up set.
- R8: If a source's input is high in the same cycle that a fetch clears its flag, the flag stays set.
- R9: Control register bit 0 at address 0x00 is the global enable. While it is 0, no request line is high, an accept returns no vector, and no flag changes because of an accept.
- R10: Control register bits 14:8 are read-only. They hold the most recently fetched vector number, updated at the edge after each fetch.
- R11: req_top_valid is high when any request line is high. req_top_grp then gives the lowest-numbered requesting group, because group 0 has the highest priority.
- R12: An accept whose group index is 12 or higher, or that names a group with no active request, returns no vector and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | 96 | Source interrupt levels; bit g*8+b is source b of group g |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data, combinational on bus_addr |
| cpu_req | output | 12 | One request line per group |
| req_top_valid | output | 1 | Some request line is high |
| req_top_grp | output | 4 | Lowest-numbered requesting group |
| cpu_ack_valid | input | 1 | Processor accepts a request this cycle |
| cpu_ack_grp | input | 4 | Index of the group being accepted |
| vec_valid | output | 1 | vec_num is valid this cycle |
| vec_num | output | 7 | Vector number returned for the accept |

## Verification
A vector fetch and a new arrival on the same source can land in the same cycle. The fetch tries to clear the flag, and the arrival tries to set it. The bench provokes this by raising the source input during the accept cycle. It judges the outcome by reading the flag back over the bus: the flag must still be set, and the acknowledge bit must be set. A fetch can also collide with a software write that clears the same group's acknowledge bit. The bench drives the write and the accept in one cycle and expects the acknowledge bit to read back as set.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

    localparam int unsigned NUM_GRP     = 12;
    localparam int unsigned SRC_PER_GRP = 8;
    localparam int unsigned BUS_DW      = 16;
    localparam int unsigned BUS_AW      = 6;

    localparam int unsigned SRC_IW = $clog2(SRC_PER_GRP);
    localparam int unsigned GRP_IW = $clog2(NUM_GRP + 1);
    localparam int unsigned VEC_W  = $clog2(NUM_GRP * SRC_PER_GRP);

    localparam int unsigned A_CTRL      = 0;
    localparam int unsigned A_ACK       = 1;
    localparam int unsigned A_FLAG_BASE = 16;
    localparam int unsigned A_EN_BASE   = 32;

    localparam int unsigned CTRL_EN_BIT = 0;
    localparam int unsigned CTRL_LV_LSB = 8;

    typedef struct packed {
        logic              hit;
        logic [SRC_IW-1:0] idx;
    } src_pick_t;

    typedef struct packed {
        logic              hit;
        logic [GRP_IW-1:0] idx;
    } grp_pick_t;

    // Lowest set bit wins.
    function automatic src_pick_t pick_src(input logic [SRC_PER_GRP-1:0] v);
        src_pick_t r;
        r = '0;
        for (int i = SRC_PER_GRP - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.hit = 1'b1;
                r.idx = SRC_IW'(i);
            end
        end
        return r;
    endfunction

    function automatic grp_pick_t pick_grp(input logic [NUM_GRP-1:0] v);
        grp_pick_t r;
        r = '0;
        for (int i = NUM_GRP - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.hit = 1'b1;
                r.idx = GRP_IW'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irqx_group.sv
module irqx_group
    import irqx_pkg::*;
#(
    parameter int unsigned S = SRC_PER_GRP
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         gen,
    input  logic [S-1:0] src,
    input  logic         flag_we,
    input  logic         en_we,
    input  logic [S-1:0] wdata,
    input  logic         ack_clr,
    input  logic         fetch,
    output logic [S-1:0] flag,
    output logic [S-1:0] en,
    output logic         ack,
    output logic         req,
    output src_pick_t    pick
);

    logic [S-1:0] flag_d;
    logic         ack_d;

    always_comb begin
        pick = pick_src(flag & en);
        req  = gen && !ack && pick.hit;
    end

    // Order: fetch clear, then bus write, then arrivals on top.
    always_comb begin
        flag_d = flag;
        if (fetch) flag_d[pick.idx] = 1'b0;
        if (flag_we) flag_d = wdata;
        flag_d = flag_d | src;
    end

    // A fetch outranks a software clear in the same cycle.
    always_comb begin
        ack_d = ack;
        if (ack_clr) ack_d = 1'b0;
        if (fetch)   ack_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= '0;
            en   <= '0;
            ack  <= 1'b0;
        end else begin
            flag <= flag_d;
            ack  <= ack_d;
            if (en_we) en <= wdata;
        end
    end

    // R6
    fetch_sets_ack_chk: assert property (@(posedge clk) disable iff (rst)
        fetch |=> ack);

    // R7
    ack_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !ack_clr) |=> ack);

    // R6
    fetch_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch && !flag_we && !src[pick.idx]) |=> !flag[$past(pick.idx)]);

    // R3
    arrival_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (src != '0) |=> ((flag & $past(src)) == $past(src)));

    // R4
    no_req_when_acked_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> !req);

endmodule

// File: rtl/irqx_regbus.sv
module irqx_regbus
    import irqx_pkg::*;
#(
    parameter int unsigned N  = NUM_GRP,
    parameter int unsigned S  = SRC_PER_GRP,
    parameter int unsigned DW = BUS_DW,
    parameter int unsigned AW = BUS_AW,
    parameter int unsigned VW = VEC_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [N-1:0][S-1:0] flags,
    input  logic [N-1:0][S-1:0] ens,
    input  logic [N-1:0]        acks,
    input  logic [VW-1:0]       last_vec,
    output logic                gen,
    output logic [N-1:0]        flag_we,
    output logic [N-1:0]        en_we,
    output logic [N-1:0]        ack_clr,
    output logic [S-1:0]        wbyte
);

    localparam logic [AW-1:0] ADDR_CTRL = AW'(A_CTRL);
    localparam logic [AW-1:0] ADDR_ACK  = AW'(A_ACK);

    assign wbyte   = bus_wdata[S-1:0];
    assign ack_clr = (bus_we && bus_addr == ADDR_ACK) ? bus_wdata[N-1:0] : '0;

    for (genvar g = 0; g < N; g++) begin : g_dec
        assign flag_we[g] = bus_we && (bus_addr == AW'(A_FLAG_BASE + g));
        assign en_we[g]   = bus_we && (bus_addr == AW'(A_EN_BASE + g));
    end

    always_ff @(posedge clk) begin
        if (rst) gen <= 1'b0;
        else if (bus_we && bus_addr == ADDR_CTRL) gen <= bus_wdata[CTRL_EN_BIT];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTRL) begin
            bus_rdata[CTRL_EN_BIT]           = gen;
            bus_rdata[CTRL_LV_LSB +: VW]     = last_vec;
        end else if (bus_addr == ADDR_ACK) begin
            bus_rdata[N-1:0] = acks;
        end else begin
            for (int g = 0; g < N; g++) begin
                if (bus_addr == AW'(A_FLAG_BASE + g)) bus_rdata[S-1:0] = flags[g];
                if (bus_addr == AW'(A_EN_BASE + g))   bus_rdata[S-1:0] = ens[g];
            end
        end
    end

    // R2
    upper_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr >= AW'(A_FLAG_BASE)) |-> (bus_rdata[DW-1:S] == '0));

    // R9
    gen_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_CTRL) |=> (gen == $past(bus_wdata[CTRL_EN_BIT])));

endmodule

// File: rtl/irqx_vector.sv
module irqx_vector
    import irqx_pkg::*;
#(
    parameter int unsigned N  = NUM_GRP,
    parameter int unsigned S  = SRC_PER_GRP,
    parameter int unsigned GW = GRP_IW,
    parameter int unsigned VW = VEC_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         req,
    input  src_pick_t [N-1:0]    picks,
    input  logic                 ack_valid,
    input  logic [GW-1:0]        ack_grp,
    output logic [N-1:0]         fetch,
    output logic                 vec_valid,
    output logic [VW-1:0]        vec_num,
    output logic [VW-1:0]        last_vec,
    output logic                 top_valid,
    output logic [GW-1:0]        top_grp
);

    grp_pick_t top;

    for (genvar g = 0; g < N; g++) begin : g_sel
        assign fetch[g] = ack_valid && (ack_grp == GW'(g)) && req[g];
    end

    always_comb begin
        vec_valid = |fetch;
        vec_num   = '0;
        for (int g = 0; g < N; g++) begin
            if (fetch[g]) vec_num = VW'(g * S) + VW'(picks[g].idx);
        end
        top       = pick_grp(req);
        top_valid = top.hit;
        top_grp   = top.idx;
    end

    always_ff @(posedge clk) begin
        if (rst)            last_vec <= '0;
        else if (vec_valid) last_vec <= vec_num;
    end

    // R5
    single_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fetch));

    // R10
    last_vec_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |=> (last_vec == $past(vec_num)));

    // R12
    no_vec_without_req_chk: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |-> !vec_valid);

endmodule

// File: rtl/irqx_top.sv
module irqx_top
    import irqx_pkg::*;
#(
    parameter int unsigned N  = NUM_GRP,
    parameter int unsigned S  = SRC_PER_GRP,
    parameter int unsigned DW = BUS_DW,
    parameter int unsigned AW = BUS_AW,
    parameter int unsigned GW = GRP_IW,
    parameter int unsigned VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N*S-1:0] src_irq,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [N-1:0]  cpu_req,
    output logic          req_top_valid,
    output logic [GW-1:0] req_top_grp,
    input  logic          cpu_ack_valid,
    input  logic [GW-1:0] cpu_ack_grp,
    output logic          vec_valid,
    output logic [VW-1:0] vec_num
);

    logic                gen;
    logic [N-1:0][S-1:0] flags;
    logic [N-1:0][S-1:0] ens;
    logic [N-1:0]        acks;
    logic [N-1:0]        flag_we;
    logic [N-1:0]        en_we;
    logic [N-1:0]        ack_clr;
    logic [N-1:0]        fetch;
    logic [S-1:0]        wbyte;
    logic [VW-1:0]       last_vec;
    src_pick_t [N-1:0]   picks;

    irqx_regbus #(.N(N), .S(S), .DW(DW), .AW(AW), .VW(VW)) regbus_i (
        .clk      (clk),
        .rst      (rst),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .flags    (flags),
        .ens      (ens),
        .acks     (acks),
        .last_vec (last_vec),
        .gen      (gen),
        .flag_we  (flag_we),
        .en_we    (en_we),
        .ack_clr  (ack_clr),
        .wbyte    (wbyte)
    );

    for (genvar g = 0; g < N; g++) begin : g_grp
        irqx_group #(.S(S)) grp_i (
            .clk    (clk),
            .rst    (rst),
            .gen    (gen),
            .src    (src_irq[g*S +: S]),
            .flag_we(flag_we[g]),
            .en_we  (en_we[g]),
            .wdata  (wbyte),
            .ack_clr(ack_clr[g]),
            .fetch  (fetch[g]),
            .flag   (flags[g]),
            .en     (ens[g]),
            .ack    (acks[g]),
            .req    (cpu_req[g]),
            .pick   (picks[g])
        );
    end

    irqx_vector #(.N(N), .S(S), .GW(GW), .VW(VW)) vector_i (
        .clk      (clk),
        .rst      (rst),
        .req      (cpu_req),
        .picks    (picks),
        .ack_valid(cpu_ack_valid),
        .ack_grp  (cpu_ack_grp),
        .fetch    (fetch),
        .vec_valid(vec_valid),
        .vec_num  (vec_num),
        .last_vec (last_vec),
        .top_valid(req_top_valid),
        .top_grp  (req_top_grp)
    );

    // R9
    quiet_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        !gen |-> (cpu_req == '0 && !vec_valid));

    // R11
    top_is_requesting_chk: assert property (@(posedge clk) disable iff (rst)
        req_top_valid |-> cpu_req[req_top_grp]);

    // R1
    idle_after_reset_chk: assert property (@(posedge clk)
        $fell(rst) |-> (cpu_req == '0));

endmodule

// File: tb/irqx_top_tb.sv
module irqx_top_tb_top;
    import irqx_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0] grp;
        logic [7:0] flg;
        logic [7:0] en;
        logic [6:0] vec;
    } vrow_t;

    localparam vrow_t TBL [6] = '{
        '{4'd0,  8'h01, 8'hFF, 7'd0},
        '{4'd0,  8'h80, 8'hFF, 7'd7},
        '{4'd2,  8'h0C, 8'hFF, 7'd18},
        '{4'd5,  8'hF0, 8'h60, 7'd45},
        '{4'd11, 8'h81, 8'h80, 7'd95},
        '{4'd7,  8'h06, 8'h04, 7'd58}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [95:0] src_irq = '0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [11:0] cpu_req;
    logic        req_top_valid;
    logic [3:0]  req_top_grp;
    logic        cpu_ack_valid = 1'b0;
    logic [3:0]  cpu_ack_grp = '0;
    logic        vec_valid;
    logic [6:0]  vec_num;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqx_top dut_i (
        .clk(clk), .rst(rst), .src_irq(src_irq),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_req(cpu_req), .req_top_valid(req_top_valid), .req_top_grp(req_top_grp),
        .cpu_ack_valid(cpu_ack_valid), .cpu_ack_grp(cpu_ack_grp),
        .vec_valid(vec_valid), .vec_num(vec_num)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 6'(a); bus_wdata = 16'(d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_addr = 6'(a);
        #1 d = int'(bus_rdata);
    endtask

    task automatic accept(input int g, output int ok, output int v);
        @(negedge clk);
        cpu_ack_valid = 1'b1; cpu_ack_grp = 4'(g);
        #1 ok = int'(vec_valid); v = int'(vec_num);
        @(negedge clk);
        cpu_ack_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int d, ok, v;

        // R1: reset state
        do_reset();
        #1 chk("R1 cpu_req after reset", int'(cpu_req), 0);
        rd(A_CTRL, d);       chk("R1 ctrl after reset", d, 0);
        rd(A_ACK, d);        chk("R1 ack after reset", d, 0);
        rd(A_FLAG_BASE+4, d); chk("R1 flag after reset", d, 0);
        rd(A_EN_BASE+4, d);   chk("R1 enable after reset", d, 0);

        // R2: upper byte ignored
        wr(A_EN_BASE+3, 16'hFFFF);
        rd(A_EN_BASE+3, d);   chk("R2 enable upper bits", d, 16'h00FF);
        wr(A_FLAG_BASE+3, 16'hFF00);
        rd(A_FLAG_BASE+3, d); chk("R2 flag upper bits", d, 0);

        // Table walk: R4 R5 R6 R7 R10 R11
        foreach (TBL[i]) begin
            do_reset();
            wr(A_CTRL, 1);
            wr(A_FLAG_BASE + TBL[i].grp, TBL[i].flg);
            wr(A_EN_BASE + TBL[i].grp, TBL[i].en);
            #1;
            chk("R4 request raised", int'(cpu_req), 1 << TBL[i].grp);
            chk("R11 top group", int'(req_top_grp), TBL[i].grp);
            accept(TBL[i].grp, ok, v);
            chk("R5 vec_valid", ok, 1);
            chk("R5 vector number", v, TBL[i].vec);
            rd(A_FLAG_BASE + TBL[i].grp, d);
            chk("R6 chosen flag cleared", d,
                TBL[i].flg & ~(1 << (TBL[i].vec - TBL[i].grp * 8)));
            rd(A_ACK, d);  chk("R6 ack bit set", d, 1 << TBL[i].grp);
            chk("R6 request dropped", int'(cpu_req), 0);
            rd(A_CTRL, d); chk("R10 last vector", d, (TBL[i].vec << 8) | 1);
        end

        // R3 arrival with global enable off, R9 quiet
        do_reset();
        @(negedge clk); src_irq[2*8+5] = 1'b1;
        @(negedge clk); src_irq[2*8+5] = 1'b0;
        rd(A_FLAG_BASE+2, d); chk("R3 arrival sets flag", d, 16'h0020);
        wr(A_EN_BASE+2, 16'h00FF);
        #1 chk("R9 no request while disabled", int'(cpu_req), 0);
        accept(2, ok, v);      chk("R9 no vector while disabled", ok, 0);
        rd(A_FLAG_BASE+2, d);  chk("R9 flag kept while disabled", d, 16'h0020);

        // R7 acknowledge gating
        wr(A_CTRL, 1);
        #1 chk("R4 request after enable", int'(cpu_req), 16'h0004);
        accept(2, ok, v);      chk("R5 vector group 2", v, 21);
        wr(A_FLAG_BASE+2, 16'h0040);
        #1 chk("R7 silent while acked", int'(cpu_req), 0);
        wr(A_ACK, 0);
        rd(A_ACK, d);          chk("R7 write 0 no effect", d, 16'h0004);
        #1 chk("R7 still silent", int'(cpu_req), 0);
        wr(A_ACK, 16'h0004);
        #1 chk("R7 re-armed request", int'(cpu_req), 16'h0004);
        accept(2, ok, v);      chk("R5 next vector", v, 22);

        // R8 arrival collides with fetch
        do_reset();
        wr(A_CTRL, 1);
        wr(A_EN_BASE+0, 16'h00FF);
        wr(A_FLAG_BASE+0, 16'h0001);
        @(negedge clk);
        cpu_ack_valid = 1'b1; cpu_ack_grp = 4'd0; src_irq[0] = 1'b1;
        #1 chk("R8 vector in collision", int'(vec_num), 0);
        @(negedge clk);
        cpu_ack_valid = 1'b0; src_irq[0] = 1'b0;
        rd(A_FLAG_BASE+0, d);  chk("R8 flag survives fetch", d, 16'h0001);
        rd(A_ACK, d);          chk("R8 ack set", d, 16'h0001);

        // R7 fetch and ack clear in the same cycle
        wr(A_ACK, 16'h0001);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 6'(A_ACK); bus_wdata = 16'h0001;
        cpu_ack_valid = 1'b1; cpu_ack_grp = 4'd0;
        @(negedge clk);
        bus_we = 1'b0; cpu_ack_valid = 1'b0;
        rd(A_ACK, d);          chk("R7 fetch beats clear", d, 16'h0001);

        // R11 group priority, R12 out-of-range accept
        do_reset();
        wr(A_CTRL, 1);
        wr(A_EN_BASE+4, 16'h00FF);
        wr(A_EN_BASE+9, 16'h00FF);
        wr(A_FLAG_BASE+4, 16'h0001);
        wr(A_FLAG_BASE+9, 16'h0001);
        #1 chk("R11 both lines", int'(cpu_req), (1 << 4) | (1 << 9));
        chk("R11 top is lower group", int'(req_top_grp), 4);
        accept(13, ok, v);     chk("R12 out-of-range accept", ok, 0);
        accept(6, ok, v);      chk("R12 idle group accept", ok, 0);
        rd(A_ACK, d);          chk("R12 no ack change", d, 0);
        accept(9, ok, v);      chk("R5 lower-priority fetch", v, 72);
        #1 chk("R11 top after fetch", int'(req_top_grp), 4);
        chk("R11 top valid", int'(req_top_valid), 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule